// File: doc/BRIEF.md
# SDRAM Refresh Sequencer

This block produces the refresh traffic for an SDRAM attached to a bus controller. An interval timer raises periodic auto-refresh requests. Each request, once the bus is idle, becomes a precharge-all, a one-cycle wait and a refresh command, followed by a fixed recovery gap. A mode bit instead takes the device into self-refresh. The same precharge and wait lead to a refresh command issued with CKE low, and CKE stays low until software clears the mode bit.

Self-refresh is held through chip standby and through a manual reset. Only a power-on reset, which clears every register of the block, takes the device out of it. When the mode bit is cleared, CKE rises first and NOP cycles cover the recovery time. Auto-refresh then resumes from the timer. Preloading the timer counter to one below the compare value makes the first refresh follow at the next prescaler tick.

Top module: `sdr_refresh_seq`

## Requirements
- R1: While and after power-on reset (`por_n` low), `sd_cke` is 1, the command is deselect (`sd_cs_n`, `sd_ras_n`, `sd_cas_n`, `sd_we_n` all 1), `sd_a10` is 0, `sd_drv` is 1 and `bus_req` is 0.
- R2: Registers are written with `cfg_we`=1, and `cfg_sel` picks the register. Code 0 is control: bit 0 enables refresh, bit 1 selects self-refresh (0 selects auto), bit 2 keeps the pins driven in standby. Code 1 is the interval counter and code 2 is the compare value. The compare value resets to all ones. With refresh enabled in auto mode, the counter advances once every PRESCALE cycles. The advance that would make it equal the compare value instead returns it to 0 and marks a refresh pending. Successive precharge-all commands are therefore compare×PRESCALE cycles apart.
- R3: With the counter preloaded to compare−1 and the prescaler cleared by that write, enabling auto mode makes the precharge-all appear PRESCALE+1 cycles after the enabling write.
- R4: An auto-refresh is a precharge-all (cs,ras,cas,we = 0,0,1,0 with `sd_a10`=1), then one deselect cycle, then a refresh command (0,0,0,1) with `sd_cke`=1. After it, TRC cycles of deselect follow before any other command.
- R5: No sequence starts while `bus_idle` is 0. `bus_req` is 1 while a refresh is pending, and the precharge-all follows one cycle after `bus_idle` returns to 1.
- R6: Setting the self-refresh bit with refresh enabled and the bus idle gives a precharge-all one cycle after the write. One deselect cycle follows, then a refresh command with `sd_cke` low, and `sd_cke` stays low.
- R7: During standby (`stby`=1) self-refresh is kept and remains in force after standby ends. `sd_drv` is 0 in standby unless control bit 2 is 1.
- R8: Holding `mrst_n` low does not end self-refresh and clears a pending refresh request.
- R9: Clearing the self-refresh bit raises `sd_cke` one cycle after the write. Deselect is held for TRC cycles. With refresh still enabled in auto mode, the timer restarts, so a preloaded counter yields a precharge-all TRC+1 cycles after the CKE rise.
- R10: A power-on reset during self-refresh raises `sd_cke` at once and clears the control bits, so no further refresh is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| stby | input | 1 | Chip standby |
| bus_idle | input | 1 | Bus free for a refresh sequence |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select code |
| cfg_wdata | input | CNT_W | Register write data |
| bus_req | output | 1 | Refresh wants or holds the bus |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_a10 | output | 1 | Address bit wired to SDRAM A10 |
| sd_drv | output | 1 | Control pin drive enable (0 = high impedance) |

## Verification
Every command is due a fixed number of cycles after the register write or input change that causes it. A preloaded auto-refresh gives a precharge-all PRESCALE+1 cycles after the enabling write and its refresh command two cycles later. A self-refresh entry gives a precharge-all one cycle after the write. On exit, the CKE rise comes one cycle after the write and the resumed precharge-all TRC+1 cycles after that. The driver stamps each expected event with an absolute cycle counted from the edge that completed the write. The monitor samples the pins at the falling edge and compares each command or CKE change it sees, in kind and cycle, against the head of the queue. Any event it sees while the queue is empty counts as a failure.

// File: rtl/sdr_rf_pkg.sv
package sdr_rf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_PWAIT,
      ST_AREF,
      ST_SENTER,
      ST_SELF,
      ST_RCOV
   } rf_state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sd_cmd_t;

   localparam sd_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam sd_cmd_t CMD_PALL  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
   localparam sd_cmd_t CMD_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

   localparam logic [1:0] SEL_CTRL  = 2'd0;
   localparam logic [1:0] SEL_CNT   = 2'd1;
   localparam logic [1:0] SEL_CMPV  = 2'd2;

   typedef struct packed {
      logic drv_stby;
      logic self_mode;
      logic enable;
   } rf_ctrl_t;

endpackage

// File: rtl/sdr_rf_regs.sv
module sdr_rf_regs
   import sdr_rf_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [CNT_W-1:0] cfg_wdata,
   output rf_ctrl_t         ctrl,
   output logic [CNT_W-1:0] cmp_val,
   output logic             cnt_load
);

   localparam int CTRL_W = $bits(rf_ctrl_t);

   logic ctrl_wr, cmp_wr;

   assign ctrl_wr  = cfg_we && (cfg_sel == SEL_CTRL);
   assign cmp_wr   = cfg_we && (cfg_sel == SEL_CMPV);
   assign cnt_load = cfg_we && (cfg_sel == SEL_CNT);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ctrl <= '0;
      end else if (ctrl_wr) begin
         ctrl <= rf_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cmp_val <= '1;
      end else if (cmp_wr) begin
         cmp_val <= cfg_wdata;
      end
   end

endmodule

// File: rtl/sdr_rf_timer.sv
module sdr_rf_timer #(
   parameter int CNT_W    = 8,
   parameter int PRESCALE = 4
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst_n,
   input  logic             run,
   input  logic             cnt_load,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             pend_clr,
   output logic             pend
);

   logic             tick;
   logic             match;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   generate
      if (PRESCALE == 1) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         localparam int PRE_W = $clog2(PRESCALE);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               pre_q <= '0;
            end else if (!mrst_n || cnt_load) begin
               pre_q <= '0;
            end else if (run) begin
               pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
            end
         end

         assign tick = run && (pre_q == PRE_LAST);
      end
   endgenerate

   assign cnt_inc = cnt_q + 1'b1;
   assign match   = tick && !cnt_load && (cnt_inc == cmp_val);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= '0;
      end else if (cnt_load) begin
         cnt_q <= cnt_wdata;
      end else if (tick) begin
         cnt_q <= match ? '0 : cnt_inc;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pend <= 1'b0;
      end else if (!mrst_n) begin
         pend <= 1'b0;
      end else if (match) begin
         pend <= 1'b1;
      end else if (pend_clr) begin
         pend <= 1'b0;
      end
   end

endmodule

// File: rtl/sdr_rf_fsm.sv
module sdr_rf_fsm
   import sdr_rf_pkg::*;
#(
   parameter int TRC = 3
) (
   input  logic      clk,
   input  logic      por_n,
   input  logic      mrst_n,
   input  logic      stby,
   input  logic      bus_idle,
   input  logic      enable,
   input  logic      self_mode,
   input  logic      pend,
   output rf_state_e state,
   output logic      pend_clr,
   output logic      bus_req
);

   localparam int RC_W = (TRC < 2) ? 1 : $clog2(TRC);
   localparam logic [RC_W-1:0] RC_LOAD = RC_W'(TRC - 1);

   rf_state_e       state_nx;
   logic [RC_W-1:0] rc_q;
   logic            self_q;
   logic            want;
   logic            start;
   logic            leave_self;

   assign want       = enable && (self_mode || pend);
   assign start      = want && bus_idle && !stby && mrst_n;
   assign leave_self = !(enable && self_mode) && !stby && mrst_n;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:   if (start) state_nx = ST_PRE;
         ST_PRE:    state_nx = ST_PWAIT;
         ST_PWAIT:  state_nx = self_q ? ST_SENTER : ST_AREF;
         ST_AREF:   state_nx = ST_RCOV;
         ST_SENTER: state_nx = ST_SELF;
         ST_SELF:   if (leave_self) state_nx = ST_RCOV;
         ST_RCOV:   if (rc_q == '0) state_nx = ST_IDLE;
         default:   state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state <= ST_IDLE;
      end else begin
         state <= state_nx;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         self_q <= 1'b0;
      end else if (state == ST_IDLE && start) begin
         self_q <= self_mode;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rc_q <= '0;
      end else if (state_nx == ST_RCOV && state != ST_RCOV) begin
         rc_q <= RC_LOAD;
      end else if (state == ST_RCOV && rc_q != '0) begin
         rc_q <= rc_q - 1'b1;
      end
   end

   assign pend_clr = (state == ST_AREF);
   assign bus_req  = (state != ST_IDLE) || want;

endmodule

// File: rtl/sdr_rf_pins.sv
module sdr_rf_pins
   import sdr_rf_pkg::*;
(
   input  rf_state_e state,
   input  logic      stby,
   input  logic      drv_stby,
   output sd_cmd_t   cmd,
   output logic      cke,
   output logic      a10,
   output logic      drv
);

   always_comb begin
      cmd = CMD_DESEL;
      unique case (state)
         ST_PRE:    cmd = CMD_PALL;
         ST_AREF,
         ST_SENTER: cmd = CMD_REF;
         default:   cmd = CMD_DESEL;
      endcase
   end

   assign cke = !((state == ST_SENTER) || (state == ST_SELF));
   assign a10 = (state == ST_PRE);
   assign drv = !stby || drv_stby;

endmodule

// File: rtl/sdr_refresh_seq.sv
module sdr_refresh_seq
   import sdr_rf_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int PRESCALE = 4,
   parameter int TRC      = 3
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst_n,
   input  logic             stby,
   input  logic             bus_idle,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [CNT_W-1:0] cfg_wdata,
   output logic             bus_req,
   output logic             sd_cke,
   output logic             sd_cs_n,
   output logic             sd_ras_n,
   output logic             sd_cas_n,
   output logic             sd_we_n,
   output logic             sd_a10,
   output logic             sd_drv
);

   generate
      if (CNT_W < $bits(rf_ctrl_t)) begin : g_bad_cnt_w
         $error("CNT_W must hold the control bits");
      end
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("PRESCALE must be at least 1");
      end
      if (TRC < 1) begin : g_bad_trc
         $error("TRC must be at least 1");
      end
   endgenerate

   rf_ctrl_t         ctrl;
   logic [CNT_W-1:0] cmp_val;
   logic             cnt_load;
   logic             pend;
   logic             pend_clr;
   logic             tmr_run;
   rf_state_e        state;
   sd_cmd_t          cmd;

   sdr_rf_regs #(.CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .por_n     (por_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .ctrl      (ctrl),
      .cmp_val   (cmp_val),
      .cnt_load  (cnt_load)
   );

   assign tmr_run = ctrl.enable && !ctrl.self_mode && !stby && mrst_n;

   sdr_rf_timer #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_timer (
      .clk       (clk),
      .por_n     (por_n),
      .mrst_n    (mrst_n),
      .run       (tmr_run),
      .cnt_load  (cnt_load),
      .cnt_wdata (cfg_wdata),
      .cmp_val   (cmp_val),
      .pend_clr  (pend_clr),
      .pend      (pend)
   );

   sdr_rf_fsm #(.TRC(TRC)) u_fsm (
      .clk       (clk),
      .por_n     (por_n),
      .mrst_n    (mrst_n),
      .stby      (stby),
      .bus_idle  (bus_idle),
      .enable    (ctrl.enable),
      .self_mode (ctrl.self_mode),
      .pend      (pend),
      .state     (state),
      .pend_clr  (pend_clr),
      .bus_req   (bus_req)
   );

   sdr_rf_pins u_pins (
      .state    (state),
      .stby     (stby),
      .drv_stby (ctrl.drv_stby),
      .cmd      (cmd),
      .cke      (sd_cke),
      .a10      (sd_a10),
      .drv      (sd_drv)
   );

   assign sd_cs_n  = cmd.cs_n;
   assign sd_ras_n = cmd.ras_n;
   assign sd_cas_n = cmd.cas_n;
   assign sd_we_n  = cmd.we_n;

endmodule

// File: rtl/sdr_refresh_seq_chk.sv
module sdr_refresh_seq_chk #(
   parameter int TRC = 3
) (
   input logic clk,
   input logic por_n,
   input logic mrst_n,
   input logic stby,
   input logic bus_idle,
   input logic sd_cke,
   input logic sd_cs_n,
   input logic sd_ras_n,
   input logic sd_cas_n,
   input logic sd_we_n,
   input logic sd_a10
);

   localparam int GAP_W = $clog2(TRC + 1);

   logic             is_desel, is_pall, is_ref;
   logic [GAP_W-1:0] gap_q;

   assign is_desel = sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n;
   assign is_pall  = !sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n;
   assign is_ref   = !sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n;

   // cycles left in the recovery window after an auto-refresh command
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         gap_q <= '0;
      end else if (is_ref && sd_cke) begin
         gap_q <= GAP_W'(TRC);
      end else if (gap_q != '0) begin
         gap_q <= gap_q - 1'b1;
      end
   end

   a_r4_pall_a10: assert property (@(posedge clk) disable iff (!por_n)
      is_pall |-> sd_a10);

   a_r4_ref_after_wait: assert property (@(posedge clk) disable iff (!por_n)
      is_ref |-> $past(is_desel));

   a_r4_trc_nop: assert property (@(posedge clk) disable iff (!por_n)
      (gap_q != '0) |-> is_desel);

   a_r5_idle_gate: assert property (@(posedge clk) disable iff (!por_n)
      is_pall |-> $past(bus_idle));

   a_r6_cke_fall_ref: assert property (@(posedge clk) disable iff (!por_n)
      $fell(sd_cke) |-> is_ref);

   a_r7_stby_hold: assert property (@(posedge clk) disable iff (!por_n)
      (stby && !sd_cke) |=> !sd_cke);

   a_r8_mrst_hold: assert property (@(posedge clk) disable iff (!por_n)
      (!mrst_n && !sd_cke) |=> !sd_cke);

   a_r9_exit_nop: assert property (@(posedge clk) disable iff (!por_n)
      $rose(sd_cke) |-> (is_desel ##1 is_desel));

endmodule

bind sdr_refresh_seq sdr_refresh_seq_chk #(.TRC(TRC)) u_chk (
   .clk      (clk),
   .por_n    (por_n),
   .mrst_n   (mrst_n),
   .stby     (stby),
   .bus_idle (bus_idle),
   .sd_cke   (sd_cke),
   .sd_cs_n  (sd_cs_n),
   .sd_ras_n (sd_ras_n),
   .sd_cas_n (sd_cas_n),
   .sd_we_n  (sd_we_n),
   .sd_a10   (sd_a10)
);

// File: tb/tb_sdr_refresh_seq.sv
module tb_sdr_refresh_seq;

   localparam int CNT_W    = 8;
   localparam int PRESCALE = 4;
   localparam int TRC      = 3;
   localparam int CMPV     = 5;

   logic             clk = 1'b0;
   logic             por_n = 1'b0;
   logic             mrst_n = 1'b1;
   logic             stby = 1'b0;
   logic             bus_idle = 1'b1;
   logic             cfg_we = 1'b0;
   logic [1:0]       cfg_sel = 2'd0;
   logic [CNT_W-1:0] cfg_wdata = '0;
   logic             bus_req, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10, sd_drv;

   sdr_refresh_seq #(.CNT_W(CNT_W), .PRESCALE(PRESCALE), .TRC(TRC)) dut (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .stby(stby), .bus_idle(bus_idle),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .bus_req(bus_req),
      .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
      .sd_we_n(sd_we_n), .sd_a10(sd_a10), .sd_drv(sd_drv)
   );

   always #4 clk = ~clk;

   typedef struct {
      byte   kind;
      int    at;
      string req;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_err = 0;
   int   last_wr = 0;
   logic prev_cke = 1'b1;
   logic done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   task automatic push(input byte kind, input int at, input string req);
      exp_t e;
      e.kind = kind;
      e.at   = at;
      e.req  = req;
      exp_q.push_back(e);
   endtask

   task automatic wr(input logic [1:0] sel, input int data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_sel   = sel;
      cfg_wdata = CNT_W'(data);
      @(negedge clk);
      cfg_we  = 1'b0;
      last_wr = cyc;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_empty(input string req);
      for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
      check(req, exp_q.size(), 0);
   endtask

   // monitor: classify pin activity and compare with the scoreboard
   always @(negedge clk) begin
      byte k;
      k = 0;
      if (sd_cke && !prev_cke)                                   k = "X";
      else if (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n)    k = sd_a10 ? "P" : "?";
      else if (!sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n)    k = sd_cke ? "A" : "S";
      else if (!sd_cs_n || !sd_ras_n || !sd_cas_n || !sd_we_n)   k = "?";
      else if (!sd_cke && prev_cke)                              k = "?";
      prev_cke = sd_cke;
      if (k != 0) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_err++;
            $display("FAIL unexpected: actual %c expected none (cycle %0d)", k, cyc);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (k != e.kind || (e.at >= 0 && cyc != e.at)) begin
               n_err++;
               $display("FAIL %s: actual %c@%0d expected %c@%0d", e.req, k, cyc, e.kind, e.at);
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      idle(3);
      // R1 reset state
      check("R1 cke", sd_cke, 1);
      check("R1 cs_n", sd_cs_n, 1);
      check("R1 a10", sd_a10, 0);
      check("R1 drv", sd_drv, 1);
      check("R1 bus_req", bus_req, 0);
      por_n = 1'b1;
      idle(2);

      // R2 R3 R4: preload, interval and command order
      wr(2'd2, CMPV);
      wr(2'd1, CMPV - 1);
      wr(2'd0, 3'b001);
      push("P", last_wr + PRESCALE + 1, "R3 first refresh");
      push("A", last_wr + PRESCALE + 3, "R4 refresh after wait");
      push("P", last_wr + PRESCALE + 1 + CMPV * PRESCALE, "R2 interval");
      push("A", last_wr + PRESCALE + 3 + CMPV * PRESCALE, "R4 second refresh");
      idle(PRESCALE + 5);
      check("R4 recovery deselect", sd_cs_n, 1);
      wait_empty("R2 queue drained");
      wr(2'd0, 3'b000);
      idle(6);

      // R5 bus busy holds the request
      bus_idle = 1'b0;
      wr(2'd1, CMPV - 1);
      wr(2'd0, 3'b001);
      idle(10);
      check("R5 bus_req held", bus_req, 1);
      check("R5 no command", sd_cs_n, 1);
      bus_idle = 1'b1;
      push("P", cyc + 1, "R5 start after idle");
      push("A", cyc + 3, "R5 refresh");
      wait_empty("R5 queue drained");
      wr(2'd0, 3'b000);
      idle(6);

      // R6 self-refresh entry
      wr(2'd0, 3'b011);
      push("P", last_wr + 1, "R6 entry precharge");
      push("S", last_wr + 3, "R6 self command");
      wait_empty("R6 queue drained");
      idle(3);
      check("R6 cke low", sd_cke, 0);

      // R7 standby keeps self-refresh, drive follows bit 2
      stby = 1'b1;
      idle(3);
      check("R7 drv off", sd_drv, 0);
      check("R7 cke low in standby", sd_cke, 0);
      wr(2'd0, 3'b111);
      idle(1);
      check("R7 drv kept", sd_drv, 1);
      wr(2'd0, 3'b011);
      stby = 1'b0;
      idle(3);
      check("R7 cke low after standby", sd_cke, 0);

      // R8 manual reset keeps self-refresh
      mrst_n = 1'b0;
      idle(3);
      check("R8 cke low in manual reset", sd_cke, 0);
      wr(2'd0, 3'b001);
      idle(2);
      check("R8 cke low, exit blocked", sd_cke, 0);
      wr(2'd0, 3'b011);
      mrst_n = 1'b1;
      idle(3);
      check("R8 cke low after manual reset", sd_cke, 0);

      // R9 exit and auto-refresh rearm
      wr(2'd1, CMPV - 1);
      wr(2'd0, 3'b001);
      push("X", last_wr + 1, "R9 cke rise");
      push("P", last_wr + TRC + 2, "R9 rearmed refresh");
      push("A", last_wr + TRC + 4, "R9 refresh command");
      wait_empty("R9 queue drained");
      wr(2'd0, 3'b000);
      idle(6);

      // R10 power-on reset ends self-refresh
      wr(2'd0, 3'b011);
      push("P", last_wr + 1, "R10 entry precharge");
      push("S", last_wr + 3, "R10 self command");
      wait_empty("R10 entry drained");
      idle(2);
      push("X", -1, "R10 cke rise on reset");
      por_n = 1'b0;
      idle(2);
      check("R10 cke high", sd_cke, 1);
      check("R10 deselect", sd_cs_n, 1);
      por_n = 1'b1;
      idle(40);
      check("R10 bus_req cleared", bus_req, 0);
      check("R10 queue drained", exp_q.size(), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule